// File: doc/BRIEF.md
# T1 Transmit-Side Frame Synchronizer

This block watches an outgoing serial NRZ T1 stream, one bit per clock enable, and recovers its frame and multiframe alignment. One mode input selects the 12-frame superframe pattern or the 24-frame extended superframe pattern. In the extended format only the framing pattern bits are used; the other framing-slot bits are never checked.

The block tests one candidate bit position at a time. It collects one framing-slot bit per 193-bit frame. After a full multiframe of samples it compares them with every rotation of the pattern. A match declares alignment. A miss moves the candidate one bit later. Once aligned, it emits a one-cycle pulse after every recovered frame boundary, or only after the first frame of each multiframe when the multiframe select is set. It keeps checking the framing bits and falls back to the hunt on too many errors. A real-time loss flag, a sticky loss indication with an interrupt enable, a resynchronization request and an elastic-store bypass input complete the interface.

Top module: `t1_tx_framesync`

## Requirements
- R1: After reset, `lof` is 1 and `sync_pulse`, `lof_latched` and `irq` are 0.
- R2: With `esf_mode`=0, the framing bits of frames 1 to 12 are 1,0,0,0,1,1,0,1,1,1,0,0. `lof` falls right after the 12th consecutive matching sample at the candidate position, and not before.
- R3: With `esf_mode`=1, the framing bits of frames 4,8,12,16,20,24 are 0,0,1,0,1,1. Alignment takes 24 samples. The other framing slots are ignored, both while hunting and while aligned.
- R4: A candidate whose full multiframe of samples matches no rotation is dropped. The next bit becomes the new candidate, so a stream offset by k bits aligns after (k+1) multiframes of samples.
- R5: While aligned and `mf_sel`=0, `sync_pulse` is high for one cycle after each framing-slot bit and low at all other times.
- R6: While aligned and `mf_sel`=1, `sync_pulse` is high only after the framing-slot bit of frame 1 of each multiframe.
- R7: While aligned, 2 errors among the last 4 checked framing bits make `lof` rise right after the second error. An isolated error, or errors 4 checked bits apart, leave alignment intact.
- R8: `lof_latched` sets when alignment is lost. It stays set until a one-cycle `lof_clr` strobe. `irq` is high exactly while `lof_latched` and `irq_enable` are both 1.
- R9: When a loss and `lof_clr` fall in the same cycle, `lof_latched` ends up set.
- R10: `resync_req` returns the block to the hunt: `lof` is high in the next cycle, and a loss is latched if the block was aligned.
- R11: While `bypass` is high, `lof` and `sync_pulse` stay low, no loss is latched, and the bit position resets. After release the hunt starts at the next enabled bit.
- R12: While `bit_en` is low, `ser_in` is ignored and nothing advances, so alignment and pulse positions survive idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One serial bit is valid this cycle |
| ser_in | input | 1 | Serial NRZ data bit |
| esf_mode | input | 1 | 0: 12-frame superframe, 1: 24-frame extended superframe |
| mf_sel | input | 1 | 1: pulse on multiframe boundaries only |
| bypass | input | 1 | Elastic-store enable; holds the synchronizer idle |
| resync_req | input | 1 | Force a new hunt |
| lof_clr | input | 1 | Write-one-to-clear strobe for the sticky loss bit |
| irq_enable | input | 1 | Lets the sticky loss bit drive `irq` |
| sync_pulse | output | 1 | Recovered frame or multiframe sync pulse |
| lof | output | 1 | Real-time loss of frame (hunting) |
| lof_latched | output | 1 | Sticky loss-of-frame indication |
| irq | output | 1 | Interrupt request |

## Verification
The sticky loss bit has a set source and a clear source, and the two can land on the same clock edge. The bench provokes this while aligned. It corrupts one framing bit, then raises `lof_clr` on the same enabled cycle that carries a second corrupted framing bit. It judges the result by reading `lof_latched` right after that edge, where it must still be 1. A later lone strobe must then clear it. A second coincidence, a resync request on a framing-slot cycle, is covered by the rule that resync takes priority over the candidate slip.

// File: rtl/t1fs_pkg.sv
// Package: shared constants and pattern helpers for the T1 transmit
// frame synchronizer. Assumes frame indices count from 0 (frame 1 = 0).
package t1fs_pkg;

    localparam int FRAME_BITS  = 193;
    localparam int D4_FRAMES   = 12;
    localparam int ESF_FRAMES  = 24;
    localparam int MF_MAX      = ESF_FRAMES;
    localparam int FIDX_W      = $clog2(MF_MAX + 1);
    localparam int LOSS_WIN    = 4;
    localparam int LOSS_LIMIT  = 2;

    // Superframe framing bits, bit i = frame i+1.
    localparam logic [D4_FRAMES-1:0] D4_PATTERN = 12'b0011_1011_0001;
    // Extended-superframe pattern bits, bit k = frame 4*(k+1).
    localparam logic [5:0]           ESF_FPS    = 6'b110100;

    // Multiframe length in frames for the selected mode.
    function automatic int mf_len(input logic esf);
        return esf ? ESF_FRAMES : D4_FRAMES;
    endfunction

    // True when the framing slot of frame idx carries a pattern bit.
    function automatic logic slot_checked(input logic esf, input int idx);
        return esf ? ((idx % 4) == 3) : 1'b1;
    endfunction

    // Expected pattern bit in the framing slot of frame idx.
    function automatic logic slot_value(input logic esf, input int idx);
        return esf ? ESF_FPS[(idx / 4) % 6] : D4_PATTERN[idx % D4_FRAMES];
    endfunction

    // Sample j of h (0 = newest) belongs to frame (p - j) mod length.
    function automatic logic rot_match(input logic [MF_MAX-1:0] h,
                                       input logic esf, input int p);
        int   n;
        int   idx;
        logic ok;
        ok = 1'b1;
        n  = mf_len(esf);
        if (p >= n) ok = 1'b0;
        for (int j = 0; j < MF_MAX; j++) begin
            if (ok && j < n) begin
                idx = (p - j + n) % n;
                if (slot_checked(esf, idx) && (h[j] != slot_value(esf, idx)))
                    ok = 1'b0;
            end
        end
        return ok;
    endfunction

endpackage

// File: rtl/t1fs_bit_counter.sv
// Bit-position counter: counts enabled bits modulo the frame length and
// flags the candidate framing slot. A hold request keeps the count at the
// slot, so the next enabled bit becomes the new candidate.
// Assumes hold is only raised on a framing-slot cycle.
module t1fs_bit_counter #(
    parameter int FRAME_BITS = 193
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bit_en,
    input  logic hold,
    output logic frame_slot
);
    localparam int CW = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

    logic [CW-1:0] cnt;

    // Advance the bit position on each enabled bit unless told to hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (bit_en && !hold) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign frame_slot = (cnt == '0);

endmodule

// File: rtl/t1fs_hunt_monitor.sv
// Hunt and in-frame monitor. While hunting it collects one framing-slot
// sample per frame. After a full multiframe it compares them with every
// pattern rotation, then aligns or requests a one-bit slip. While aligned it
// tracks the frame index and counts framing errors over a sliding window.
// Assumes esf_mode is static while aligned.
module t1fs_hunt_monitor
    import t1fs_pkg::*;
#(
    parameter int WIN   = LOSS_WIN,
    parameter int LIMIT = LOSS_LIMIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              resync,
    input  logic              bit_en,
    input  logic              ser_in,
    input  logic              esf_mode,
    input  logic              frame_slot,
    output logic              in_sync,
    output logic              slip,
    output logic              drop_evt,
    output logic [FIDX_W-1:0] slot_idx
);
    logic [MF_MAX-1:0] hist, hist_n, match_vec;
    logic [FIDX_W-1:0] hcnt, hcnt_n, mlen, sel_p, fnext, fnext_inc;
    logic [WIN-2:0]    errw;
    logic [WIN-1:0]    win_n;
    logic              fslot, full, any_match, fbit_chk, fbit_err, loss;

    assign fslot     = bit_en && frame_slot;
    assign hist_n    = {hist[MF_MAX-2:0], ser_in};
    assign mlen      = FIDX_W'(mf_len(esf_mode));
    assign hcnt_n    = hcnt + 1'b1;
    assign full      = (hcnt_n == mlen);
    assign fnext_inc = (fnext == mlen - 1'b1) ? '0 : fnext + 1'b1;
    assign slot_idx  = fnext;

    // One comparator per candidate multiframe phase.
    for (genvar p = 0; p < MF_MAX; p++) begin : g_rot
        assign match_vec[p] = rot_match(hist_n, esf_mode, p);
    end

    // Pick the lowest matching phase.
    always_comb begin
        any_match = 1'b0;
        sel_p     = '0;
        for (int p = 0; p < MF_MAX; p++) begin
            if (match_vec[p] && !any_match) begin
                any_match = 1'b1;
                sel_p     = FIDX_W'(p);
            end
        end
    end

    // Framing-bit check for the frame that is due while aligned.
    always_comb begin
        fbit_chk = slot_checked(esf_mode, int'(fnext));
        fbit_err = fbit_chk && (ser_in != slot_value(esf_mode, int'(fnext)));
        win_n    = {errw, fbit_err};
        loss     = fslot && in_sync && fbit_chk && ($countones(win_n) >= LIMIT);
    end

    assign slip     = fslot && !in_sync && !resync && !clear && full && !any_match;
    assign drop_evt = in_sync && !clear && (resync || loss);

    // Hunt / aligned state machine with error window.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            in_sync <= 1'b0;
            hist    <= '0;
            hcnt    <= '0;
            errw    <= '0;
            fnext   <= '0;
        end else if (resync) begin
            in_sync <= 1'b0;
            hcnt    <= '0;
            errw    <= '0;
        end else if (fslot) begin
            if (!in_sync) begin
                hist <= hist_n;
                if (full) begin
                    hcnt <= '0;
                    if (any_match) begin
                        in_sync <= 1'b1;
                        errw    <= '0;
                        fnext   <= (sel_p == mlen - 1'b1) ? '0 : sel_p + 1'b1;
                    end
                end else begin
                    hcnt <= hcnt_n;
                end
            end else begin
                fnext <= fnext_inc;
                if (loss) begin
                    in_sync <= 1'b0;
                    hcnt    <= '0;
                    errw    <= '0;
                end else if (fbit_chk) begin
                    errw <= win_n[WIN-2:0];
                end
            end
        end
    end

    AST_ALIGN_ON_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> ($past(bit_en) && $past(frame_slot) && $past(rst_n))); // R2
    AST_DROP_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(in_sync) && $past(rst_n) && !$past(clear) && !$past(resync))
        |-> $past(bit_en)); // R7
    AST_SLIP_WHILE_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        slip |=> !in_sync); // R4

endmodule

// File: rtl/t1fs_status.sv
// Sticky loss-of-frame bit with write-one-to-clear and interrupt enable.
// Assumes set_evt is a one-cycle event; set has priority over clear.
module t1fs_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic lof_clr,
    input  logic irq_enable,
    output logic lof_latched,
    output logic irq
);
    // Hold the loss indication until software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lof_latched <= 1'b0;
        end else if (set_evt) begin
            lof_latched <= 1'b1;
        end else if (lof_clr) begin
            lof_latched <= 1'b0;
        end
    end

    assign irq = lof_latched && irq_enable;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> lof_latched); // R9
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (lof_clr && !set_evt) |=> !lof_latched); // R8

endmodule

// File: rtl/t1_tx_framesync.sv
// Top of the T1 transmit-side frame synchronizer: bit counter, hunt and
// monitor, status, and the registered sync pulse. Assumes one serial bit
// per bit_en cycle and that bypass selects the elastic-store path.
module t1_tx_framesync
    import t1fs_pkg::*;
#(
    parameter int FRAME_LEN = FRAME_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic ser_in,
    input  logic esf_mode,
    input  logic mf_sel,
    input  logic bypass,
    input  logic resync_req,
    input  logic lof_clr,
    input  logic irq_enable,
    output logic sync_pulse,
    output logic lof,
    output logic lof_latched,
    output logic irq
);
    logic              frame_slot, in_sync, slip, drop_evt;
    logic [FIDX_W-1:0] slot_idx;

    t1fs_bit_counter #(.FRAME_BITS(FRAME_LEN)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (bypass),
        .bit_en     (bit_en),
        .hold       (slip),
        .frame_slot (frame_slot)
    );

    t1fs_hunt_monitor u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (bypass),
        .resync     (resync_req),
        .bit_en     (bit_en),
        .ser_in     (ser_in),
        .esf_mode   (esf_mode),
        .frame_slot (frame_slot),
        .in_sync    (in_sync),
        .slip       (slip),
        .drop_evt   (drop_evt),
        .slot_idx   (slot_idx)
    );

    t1fs_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_evt     (drop_evt),
        .lof_clr     (lof_clr),
        .irq_enable  (irq_enable),
        .lof_latched (lof_latched),
        .irq         (irq)
    );

    // Register the frame or multiframe boundary pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || bypass) begin
            sync_pulse <= 1'b0;
        end else begin
            sync_pulse <= bit_en && frame_slot && in_sync && !resync_req &&
                          (!mf_sel || slot_idx == '0);
        end
    end

    assign lof = !in_sync && !bypass;

    AST_PULSE_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> $past(bit_en)); // R12
    AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> !sync_pulse); // R11
    AST_RESYNC_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (resync_req && !bypass) |=> (lof || bypass)); // R10

endmodule

// File: tb/test_t1_tx_framesync.sv
`timescale 1ns/1ps
module test_t1_tx_framesync;
    logic clk = 1'b0;
    logic rst_n, bit_en, ser_in, esf_mode, mf_sel, bypass, resync_req, lof_clr, irq_enable;
    logic sync_pulse, lof, lof_latched, irq;

    int n_chk = 0;
    int n_fail = 0;
    int gm = 0;
    logic dl_inv = 1'b0;
    logic pf, lf;
    int extra;
    bit done = 0;

    localparam logic [11:0] SF_SEQ  = 12'b0011_1011_0001; // bit i = frame i+1
    localparam logic [5:0]  ESF_SEQ = 6'b110100;          // bit k = frame 4(k+1)

    always #2.5 clk = ~clk;

    t1_tx_framesync i_t1_tx_framesync (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in),
        .esf_mode(esf_mode), .mf_sel(mf_sel), .bypass(bypass),
        .resync_req(resync_req), .lof_clr(lof_clr), .irq_enable(irq_enable),
        .sync_pulse(sync_pulse), .lof(lof), .lof_latched(lof_latched), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic b);
        ser_in = b;
        bit_en = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n, input logic junk);
        bit_en = 1'b0;
        ser_in = junk;
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic fbit(input int m);
        int L = esf_mode ? 24 : 12;
        int i = m % L;
        if (!esf_mode) return SF_SEQ[i];
        if (i % 4 == 3) return ESF_SEQ[i / 4];
        return dl_inv ^ logic'(m % 2);
    endfunction

    // One frame: framing slot plus 192 zero payload bits.
    task automatic send_frame(input logic corrupt, input logic clr);
        lof_clr = clr;
        drive(fbit(gm) ^ corrupt);
        lof_clr = 1'b0;
        pf = sync_pulse;
        lf = lof;
        extra = 0;
        for (int k = 0; k < 192; k++) begin
            drive(1'b0);
            extra += int'(sync_pulse);
        end
        gm++;
    endtask

    task automatic reset_dut(input logic esf);
        rst_n = 1'b0; bit_en = 1'b0; ser_in = 1'b0; esf_mode = esf; mf_sel = 1'b0;
        bypass = 1'b0; resync_req = 1'b0; lof_clr = 1'b0; irq_enable = 1'b0;
        dl_inv = 1'b0; gm = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic t_reset;
        reset_dut(1'b0);
        chk("R1 lof", lof, 1);
        chk("R1 sync_pulse", sync_pulse, 0);
        chk("R1 lof_latched", lof_latched, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_sf_align;
        int bad = 0;
        reset_dut(1'b0);
        for (int m = 0; m < 11; m++) send_frame(1'b0, 1'b0);
        chk("R2 still hunting after 11 frames", lof, 1);
        send_frame(1'b0, 1'b0);
        chk("R2 aligned after 12th frame", lf, 0);
        chk("R2 no pulse on aligning frame", pf, 0);
        for (int m = 0; m < 12; m++) begin
            send_frame(1'b0, 1'b0);
            if (pf !== 1'b1 || extra != 0) bad++;
            if (m == 5) idle(7, 1'b1);  // R12 gap with junk data
        end
        chk("R5 pulse every frame, R12 gap tolerated", bad, 0);
        chk("R12 still aligned after gap", lof, 0);
        mf_sel = 1'b1;
        bad = 0;
        for (int m = 0; m < 24; m++) begin
            send_frame(1'b0, 1'b0);
            if (pf !== logic'(((gm - 1) % 12) == 0) || extra != 0) bad++;
        end
        chk("R6 multiframe pulses only", bad, 0);
        mf_sel = 1'b0;
    endtask

    task automatic t_sf_loss;
        send_frame(1'b1, 1'b0);
        for (int m = 0; m < 3; m++) send_frame(1'b0, 1'b0);
        send_frame(1'b1, 1'b0);
        for (int m = 0; m < 3; m++) send_frame(1'b0, 1'b0);
        chk("R7 spaced errors keep alignment", lof, 0);
        chk("R8 no latch without loss", lof_latched, 0);
        send_frame(1'b1, 1'b0);
        chk("R7 one error keeps alignment", lf, 0);
        send_frame(1'b1, 1'b0);
        chk("R7 second error drops alignment", lf, 1);
        chk("R8 latched set", lof_latched, 1);
        chk("R8 irq masked", irq, 0);
        irq_enable = 1'b1;
        #1;
        chk("R8 irq enabled", irq, 1);
        lof_clr = 1'b1;
        idle(1, 1'b0);
        lof_clr = 1'b0;
        chk("R8 cleared by strobe", lof_latched, 0);
        chk("R8 irq follows clear", irq, 0);
        irq_enable = 1'b0;
        for (int m = 0; m < 12; m++) send_frame(1'b0, 1'b0);
        chk("R2 realigned after loss", lf, 0);
    endtask

    task automatic t_set_wins;
        send_frame(1'b1, 1'b0);
        send_frame(1'b1, 1'b1);
        chk("R9 loss with clear same cycle", lf, 1);
        chk("R9 set wins over clear", lof_latched, 1);
        lof_clr = 1'b1;
        idle(1, 1'b0);
        lof_clr = 1'b0;
        chk("R8 later clear", lof_latched, 0);
        for (int m = 0; m < 12; m++) send_frame(1'b0, 1'b0);
        chk("R2 realigned before resync", lf, 0);
    endtask

    task automatic t_resync;
        resync_req = 1'b1;
        idle(1, 1'b0);
        resync_req = 1'b0;
        chk("R10 lof after resync", lof, 1);
        chk("R10 resync latched", lof_latched, 1);
        for (int m = 0; m < 11; m++) send_frame(1'b0, 1'b0);
        chk("R10 hunting restarted", lf, 1);
        send_frame(1'b0, 1'b0);
        chk("R10 realigned after full multiframe", lf, 0);
        lof_clr = 1'b1;
        idle(1, 1'b0);
        lof_clr = 1'b0;
    endtask

    task automatic t_esf;
        int bad = 0;
        reset_dut(1'b1);
        mf_sel = 1'b1;
        drive(1'b0);
        drive(1'b0);
        for (int m = 0; m <= 96; m++) begin
            send_frame(1'b0, 1'b0);
            if (m == 68) chk("R4 still hunting before third candidate completes", lf, 1);
            if (m == 69) chk("R4 R3 aligned after two slips", lf, 0);
            if (m >= 70 && (pf !== logic'((m % 24) == 0) || extra != 0)) bad++;
        end
        chk("R3 R6 extended multiframe pulses", bad, 0);
        dl_inv = 1'b1;
        bad = 0;
        for (int m = 0; m < 24; m++) begin
            send_frame(1'b0, 1'b0);
            if (lf !== 1'b0) bad++;
        end
        chk("R3 non-pattern slots ignored", bad, 0);
    endtask

    task automatic t_esf_loss;
        int nerr = 0;
        while (nerr < 2) begin
            if (gm % 4 == 3) begin
                send_frame(1'b1, 1'b0);
                nerr++;
                if (nerr == 1) chk("R7 first pattern error tolerated", lf, 0);
            end else begin
                send_frame(1'b0, 1'b0);
            end
        end
        chk("R7 second pattern error drops", lf, 1);
        chk("R8 latched after extended loss", lof_latched, 1);
        lof_clr = 1'b1;
        idle(1, 1'b0);
        lof_clr = 1'b0;
    endtask

    task automatic t_bypass;
        int bad = 0;
        bypass = 1'b1;
        #1;
        chk("R11 lof idle in bypass", lof, 0);
        for (int m = 0; m < 3; m++) begin
            send_frame(1'b1, 1'b0);
            if (lf !== 1'b0 || pf !== 1'b0 || extra != 0) bad++;
        end
        chk("R11 outputs idle in bypass", bad, 0);
        chk("R11 no loss latched in bypass", lof_latched, 0);
        bypass = 1'b0;
        #1;
        chk("R11 hunting after release", lof, 1);
        for (int m = 0; m < 23; m++) send_frame(1'b0, 1'b0);
        chk("R11 not aligned before full multiframe", lf, 1);
        send_frame(1'b0, 1'b0);
        chk("R11 aligned from first bit after release", lf, 0);
    endtask

    initial begin
        t_reset();
        t_sf_align();
        t_sf_loss();
        t_set_wins();
        t_resync();
        t_esf();
        t_esf_loss();
        t_bypass();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule